// File: doc/BRIEF.md
# PWM Fault Brake Controller

This block sits between a six-channel PWM generator and the output pins. It watches a set of fault inputs (two external brake pins, three analog comparator outputs and a low-voltage detector). When a brake condition is seen, it latches a brake flag and forces the chosen PWM channels to programmed safe levels. The override stays in force until software clears the flag, and a clear is refused while the fault is still present.

There are two brake paths, and they combine their sources by different rules. Path 0 ORs together whichever of its four sources are enabled. Path 1 takes one source through a 2-bit selector and may also OR in the low-voltage detector. Each path has its own interrupt flag, gated by a per-path interrupt enable and cleared by its own strobe, apart from the brake flag. All fault inputs pass through a two-flop synchronizer before use.

Top module: `pwm_brake_ctrl`

## Requirements
- R1: After reset both brake flags and both interrupt flags are 0, `irq` is 0 and every output follows its PWM input.
- R2: Brake path 0 triggers on the OR of its sources, each gated by one bit of `b0_src_en` (bit 0 brake pin 0, bit 1 comparator 0, bit 2 comparator 1, bit 3 comparator 2). An active source whose enable bit is 0 has no effect.
- R3: Brake path 1 takes the source picked by `b1_sel`: 0 brake pin 1, 1 comparator 0, 2 comparator 1, 3 comparator 2. Sources that are not selected have no effect.
- R4: The low-voltage input also triggers brake path 1 when `b1_lvd_en` is 1, and is ignored when it is 0.
- R5: A brake flag rises at the third rising clock edge after its source goes active (two synchronizer stages, then the flag register). It then stays set after the source returns inactive.
- R6: A flag-clear strobe that arrives while the path's synchronized source is still active is ignored, and the flag stays set.
- R7: A flag-clear strobe while the synchronized source is inactive clears that flag at the next clock edge.
- R8: While any brake flag is set, each channel with its `chan_mask` bit at 1 drives its `level_mask` bit. Channels whose mask bit is 0 pass their PWM input through unchanged.
- R9: An interrupt flag sets together with its brake flag only when that path's `irq_en` bit is 1. `irq` is the OR of both interrupt flags. The flag is cleared only by its `irq_clr` bit, not by `flag_clr`, and follows the same active-source rule as R6/R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 6 | Waveforms from the PWM generator |
| brk_pin0 | input | 1 | External brake pin 0 (asynchronous) |
| brk_pin1 | input | 1 | External brake pin 1 (asynchronous) |
| cmp_in | input | 3 | Comparator outputs 0..2 (asynchronous) |
| lvd_in | input | 1 | Low-voltage detect (asynchronous) |
| b0_src_en | input | 4 | Source enables for brake path 0 |
| b1_sel | input | 2 | Source selector for brake path 1 |
| b1_lvd_en | input | 1 | Adds low-voltage detect to path 1 |
| chan_mask | input | 6 | Channels that a brake overrides |
| level_mask | input | 6 | Safe level per overridden channel |
| irq_en | input | 2 | Interrupt enable per brake path |
| flag_clr | input | 2 | Brake flag clear strobe per path |
| irq_clr | input | 2 | Interrupt flag clear strobe per path |
| pwm_out | output | 6 | Gated PWM outputs |
| brk_flag | output | 2 | Latched brake flags |
| irq_flag | output | 2 | Latched interrupt flags |
| irq | output | 1 | OR of the interrupt flags |

## Verification
On every cycle, the assertions check that the flags hold, set and clear as they should once their synchronized source is known. They also check that an interrupt flag cannot rise while its enable is off, and that each output channel carries either its safe level or its PWM input as the flags and masks direct. Some things only the bench scenarios can show, because they start at the raw asynchronous pins: the exact three-edge latency, the source enable and selector encodings, the low-voltage gate, and the independence of the two clear strobes.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int NUM_BRK = 2;
    localparam int NUM_CMP = 3;
    localparam int B0_SRCS = 1 + NUM_CMP;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        B1_PIN  = 2'd0,
        B1_CMP0 = 2'd1,
        B1_CMP1 = 2'd2,
        B1_CMP2 = 2'd3
    } b1_sel_e;

    typedef struct packed {
        logic               lvd;
        logic [NUM_CMP-1:0] cmp;
        logic               pin1;
        logic               pin0;
    } fault_t;

    localparam int FLT_W = $bits(fault_t);

    function automatic logic path0_src(input fault_t f, input logic [B0_SRCS-1:0] en);
        logic [B0_SRCS-1:0] srcs;
        srcs = {f.cmp, f.pin0};
        return |(srcs & en);
    endfunction

    function automatic logic path1_src(input fault_t f, input b1_sel_e sel, input logic lvd_en);
        logic pick;
        case (sel)
            B1_PIN:  pick = f.pin1;
            B1_CMP0: pick = f.cmp[0];
            B1_CMP1: pick = f.cmp[1];
            default: pick = f.cmp[2];
        endcase
        return pick | (f.lvd & lvd_en);
    endfunction

endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/brake_latch.sv
module brake_latch (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic irq_en,
    input  logic clr_flag,
    input  logic clr_irq,
    output logic flag_q,
    output logic irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (src)           flag_q <= 1'b1;
            else if (clr_flag) flag_q <= 1'b0;
            if (src && irq_en) irq_q <= 1'b1;
            else if (clr_irq && !src) irq_q <= 1'b0;
        end
    end

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst) src |=> flag_q);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst) (flag_q && !clr_flag) |=> flag_q);
    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst) (clr_flag && !src) |=> !flag_q);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst) (!irq_q && !irq_en) |=> !irq_q);
    // R9
    irq_keep_chk: assert property (@(posedge clk) disable iff (rst) (irq_q && !clr_irq) |=> irq_q);
endmodule

// File: rtl/out_override.sv
module out_override #(
    parameter int NCH = 6
) (
    input  logic           brake,
    input  logic [NCH-1:0] pwm_in,
    input  logic [NCH-1:0] chan_mask,
    input  logic [NCH-1:0] level_mask,
    output logic [NCH-1:0] pwm_out
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb begin
            if (brake && chan_mask[c]) pwm_out[c] = level_mask[c];
            else                       pwm_out[c] = pwm_in[c];
        end
    end
endmodule

// File: rtl/pwm_brake_ctrl.sv
module pwm_brake_ctrl
    import brk_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CH-1:0]    pwm_in,
    input  logic                 brk_pin0,
    input  logic                 brk_pin1,
    input  logic [NUM_CMP-1:0]   cmp_in,
    input  logic                 lvd_in,
    input  logic [B0_SRCS-1:0]   b0_src_en,
    input  logic [1:0]           b1_sel,
    input  logic                 b1_lvd_en,
    input  logic [NUM_CH-1:0]    chan_mask,
    input  logic [NUM_CH-1:0]    level_mask,
    input  logic [NUM_BRK-1:0]   irq_en,
    input  logic [NUM_BRK-1:0]   flag_clr,
    input  logic [NUM_BRK-1:0]   irq_clr,
    output logic [NUM_CH-1:0]    pwm_out,
    output logic [NUM_BRK-1:0]   brk_flag,
    output logic [NUM_BRK-1:0]   irq_flag,
    output logic                 irq
);
    fault_t             raw_f, syn_f;
    logic [FLT_W-1:0]   syn_vec;
    logic [NUM_BRK-1:0] src;

    always_comb begin
        raw_f.pin0 = brk_pin0;
        raw_f.pin1 = brk_pin1;
        raw_f.cmp  = cmp_in;
        raw_f.lvd  = lvd_in;
    end

    fault_sync #(.W(FLT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_f),
        .q_sync  (syn_vec)
    );

    assign syn_f  = fault_t'(syn_vec);
    assign src[0] = path0_src(syn_f, b0_src_en);
    assign src[1] = path1_src(syn_f, b1_sel_e'(b1_sel), b1_lvd_en);

    for (genvar k = 0; k < NUM_BRK; k++) begin : g_brk
        brake_latch u_latch (
            .clk      (clk),
            .rst      (rst),
            .src      (src[k]),
            .irq_en   (irq_en[k]),
            .clr_flag (flag_clr[k]),
            .clr_irq  (irq_clr[k]),
            .flag_q   (brk_flag[k]),
            .irq_q    (irq_flag[k])
        );
    end

    assign irq = |irq_flag;

    out_override #(.NCH(NUM_CH)) u_ovr (
        .brake      (|brk_flag),
        .pwm_in     (pwm_in),
        .chan_mask  (chan_mask),
        .level_mask (level_mask),
        .pwm_out    (pwm_out)
    );

    // R8
    safe_level_chk: assert property (@(posedge clk) disable iff (rst)
        (|brk_flag) |-> ((pwm_out & chan_mask) == (level_mask & chan_mask)));
    // R8
    pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
        ((pwm_out & ~chan_mask) == (pwm_in & ~chan_mask)));
    // R1
    idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_flag == '0) |-> (pwm_out == pwm_in));
endmodule

// File: tb/test_pwm_brake_ctrl.sv
`timescale 1ns/1ps
module test_pwm_brake_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] pwm_in = '0;
    logic       brk_pin0 = 0, brk_pin1 = 0, lvd_in = 0, b1_lvd_en = 0;
    logic [2:0] cmp_in = '0;
    logic [3:0] b0_src_en = '0;
    logic [1:0] b1_sel = '0, irq_en = '0, flag_clr = '0, irq_clr = '0;
    logic [5:0] chan_mask = '0, level_mask = '0;
    logic [5:0] pwm_out;
    logic [1:0] brk_flag, irq_flag;
    logic       irq;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwm_brake_ctrl i_pwm_brake_ctrl (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .brk_pin0(brk_pin0), .brk_pin1(brk_pin1),
        .cmp_in(cmp_in), .lvd_in(lvd_in), .b0_src_en(b0_src_en), .b1_sel(b1_sel),
        .b1_lvd_en(b1_lvd_en), .chan_mask(chan_mask), .level_mask(level_mask),
        .irq_en(irq_en), .flag_clr(flag_clr), .irq_clr(irq_clr), .pwm_out(pwm_out),
        .brk_flag(brk_flag), .irq_flag(irq_flag), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet_and_clear();
        brk_pin0 = 0; brk_pin1 = 0; cmp_in = '0; lvd_in = 0;
        edges(3);
        flag_clr = 2'b11; irq_clr = 2'b11;
        edges(1);
        flag_clr = '0; irq_clr = '0;
    endtask

    task automatic t_reset();
        pwm_in = 6'b101101;
        chan_mask = 6'b111111; level_mask = 6'b000000;
        edges(1);
        chk({6'b0, brk_flag}, 8'h0, "R1 brk_flag");
        chk({6'b0, irq_flag}, 8'h0, "R1 irq_flag");
        chk({7'b0, irq}, 8'h0, "R1 irq");
        chk({2'b0, pwm_out}, {2'b0, pwm_in}, "R1 pass-through");
    endtask

    task automatic t_path0();
        b0_src_en = 4'b0100;
        cmp_in = 3'b001;
        edges(4);
        chk({7'b0, brk_flag[0]}, 8'h0, "R2 disabled cmp0 ignored");
        cmp_in = 3'b011;
        edges(2);
        chk({7'b0, brk_flag[0]}, 8'h0, "R5 not yet after 2 edges");
        edges(1);
        chk({7'b0, brk_flag[0]}, 8'h1, "R5 set at third edge");
        chk({7'b0, brk_flag[1]}, 8'h0, "R2 path1 untouched");
        cmp_in = 3'b000;
        edges(5);
        chk({7'b0, brk_flag[0]}, 8'h1, "R5 held after source gone");
        flag_clr = 2'b01;
        edges(1);
        flag_clr = '0;
        chk({7'b0, brk_flag[0]}, 8'h0, "R7 cleared");
        b0_src_en = 4'b1000;
        cmp_in = 3'b100;
        edges(3);
        chk({7'b0, brk_flag[0]}, 8'h1, "R2 enabled cmp2 triggers");
        quiet_and_clear();
    endtask

    task automatic t_clear_blocked();
        b0_src_en = 4'b0001;
        brk_pin0 = 1;
        edges(3);
        flag_clr = 2'b01;
        edges(1);
        flag_clr = '0;
        edges(1);
        chk({7'b0, brk_flag[0]}, 8'h1, "R6 clear ignored while active");
        quiet_and_clear();
        chk({7'b0, brk_flag[0]}, 8'h0, "R7 clear once inactive");
        b0_src_en = '0;
    endtask

    task automatic t_path1_sel();
        for (int s = 0; s < 4; s++) begin
            logic [3:0] pat;
            logic [3:0] wrong;
            b1_sel = 2'(s);
            wrong = (s == 0) ? 4'b0010 : 4'b0001;
            {cmp_in, brk_pin1} = wrong;
            edges(4);
            chk({7'b0, brk_flag[1]}, 8'h0, $sformatf("R3 unselected ignored sel=%0d", s));
            pat = 4'b0001 << s;
            {cmp_in, brk_pin1} = pat;
            edges(3);
            chk({7'b0, brk_flag[1]}, 8'h1, $sformatf("R3 selected source sel=%0d", s));
            quiet_and_clear();
        end
        b1_sel = '0;
    endtask

    task automatic t_lvd();
        b1_lvd_en = 0;
        lvd_in = 1;
        edges(4);
        chk({7'b0, brk_flag[1]}, 8'h0, "R4 lvd ignored when disabled");
        b1_lvd_en = 1;
        edges(1);
        chk({7'b0, brk_flag[1]}, 8'h1, "R4 lvd triggers when enabled");
        quiet_and_clear();
        b1_lvd_en = 0;
    endtask

    task automatic t_override();
        chan_mask = 6'b001011; level_mask = 6'b000010; pwm_in = 6'b111101;
        brk_pin1 = 1; b1_sel = 2'd0;
        edges(3);
        chk({2'b0, pwm_out}, 8'h36, "R8 forced outputs");
        pwm_in = 6'b000000;
        edges(1);
        chk({2'b0, pwm_out}, 8'h02, "R8 unaffected channels follow pwm");
        quiet_and_clear();
        chk({2'b0, pwm_out}, {2'b0, pwm_in}, "R8 released after clear");
    endtask

    task automatic t_irq();
        b0_src_en = 4'b0001; irq_en = 2'b00;
        brk_pin0 = 1;
        edges(3);
        chk({7'b0, irq}, 8'h0, "R9 no irq when disabled");
        quiet_and_clear();
        irq_en = 2'b01;
        brk_pin0 = 1;
        edges(3);
        chk({6'b0, irq_flag}, 8'h1, "R9 irq flag set");
        chk({7'b0, irq}, 8'h1, "R9 irq out");
        brk_pin0 = 0;
        edges(3);
        flag_clr = 2'b01;
        edges(1);
        flag_clr = '0;
        chk({6'b0, brk_flag}, 8'h0, "R9 flag cleared");
        chk({6'b0, irq_flag}, 8'h1, "R9 irq flag survives flag_clr");
        irq_clr = 2'b01;
        edges(1);
        irq_clr = '0;
        chk({7'b0, irq}, 8'h0, "R9 irq cleared by irq_clr");
        irq_en = '0; b0_src_en = '0;
    endtask

    initial begin
        edges(3);
        rst = 0;
        t_reset();
        t_path0();
        t_clear_blocked();
        t_path1_sel();
        t_lvd();
        t_override();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule